// File: doc/BRIEF.md
# Clock-Synthesizer Control Register Target

This block is the register side of a serial-bus-controlled frequency synthesizer. A bit-level bus front end, which is not part of this block, decodes start conditions and whole bytes. It then hands this block a start pulse carrying the 7-bit target address, plus one read or write strobe per data byte. The block answers only on address 0x69. Behind that address it keeps up to seven 8-bit control registers, reached through a pointer that steps forward by itself. The first byte read after a start is not register data: it is the number of implemented registers.

Up to five frequency-select bits are spread across the registers. Each select bit can have a writable true copy and a write-protected inverted copy at any register and bit position, given by elaboration-time tables. At reset the copies are loaded from the strap inputs. The block continuously drives a frequency-table index: the strap value, with the register-backed select bits ORed in. Two options can be chosen per instance. One also protects the true copies from writes. The other makes register 0 read back only its revision field.

Top module: `synth_regtarget`

## Requirements
- R1: A start pulse whose address is 0x69 selects the block and raises addrAck. A start with any other address deselects it. While the block is deselected, read and write strobes change no register and do not move the pointer.
- R2: After a selecting start the block is in the count state, and rdData shows MAX_REG+1 (6 by default). A read strobe in that state moves the pointer to register 0.
- R3: Every read or write strobe outside the count state moves the pointer up by one. After register MAX_REG it wraps to register 0.
- R4: A write strobe in the count state stores nothing. It only moves the pointer to register 0.
- R5: A write keeps the old value of every bit position that holds an inverted select copy and stores wrData in the other positions. In the default map those are register 2 bits 7 and 6 (select bits 0 and 1) and register 3 bit 0 (select bit 2).
- R6: With TRUE_FIXED=1, writes also keep the true select copies. With TRUE_FIXED=0 those copies take wrData. In the default map the true copies are register 1 bits 0, 1 and 2 (select bits 0 to 2) and register 4 bit 5 (select bit 3).
- R7: freqIdx bit i equals strapSel bit i ORed with the true copy of select bit i. A select bit with neither a true nor an inverted location ignores its strap and reads 0. In the default map that is select bit 4.
- R8: At reset each register loads its RESET_VALS byte, with every true copy set to its strap bit and every inverted copy set to the complement of that bit. The default bytes for registers 0 to 5 are 12, F0, 3C, A5, 00, 5A (hex).
- R9: With REV_READ=1, a read of register 0 returns the stored byte ANDed with 0x0B. The stored value itself is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; straps are loaded while it is low |
| startStb | input | 1 | One-cycle start pulse with address; it takes priority over the strobes |
| startAddr | input | 7 | Target address that comes with the start |
| rdStb | input | 1 | One-cycle strobe: the byte on rdData has been taken |
| wrStb | input | 1 | One-cycle strobe: write wrData at the pointer |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Byte that the next read returns (count or register) |
| strapSel | input | NUM_SEL | Frequency-select strap pins |
| freqIdx | output | NUM_SEL | Assembled frequency-table index |
| addrAck | output | 1 | Block is selected by the last start |

## Verification
The bench goes after the transitions that a wrong pointer would mishandle. These are the count byte and the step to register 0, the wrap after register 5, and a write issued in the count state. An off-by-one design returns register data in place of the count or skips register 0. A design that stores the count-state write corrupts register 0. For write protection, the bench writes all-ones and all-zeros over registers that hold select copies. A missing keep-mask flips the inverted copies, and a wrongly applied TRUE_FIXED shows up in freqIdx. It also checks that the register-only select bit ignores its strap, that the revision mask shows only on register 0 of the option instance, and that strobes after a foreign address leave every register untouched.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam logic [6:0] DEV_ADDR = 7'h69;
  localparam int REGNUM_W = 3;
  localparam logic [REGNUM_W-1:0] NO_COPY = 3'd7;
  localparam logic [7:0] REV_MASK = 8'h0B;

  typedef struct packed {
    logic                wrEn;
    logic                inCount;
    logic [REGNUM_W-1:0] ptr;
  } ctrl_strobe_t;
endpackage

// File: rtl/synth_ctrl.sv
module synth_ctrl
  import synth_pkg::*;
#(
  parameter int MAX_REG = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startStb,
  input  logic [6:0]   startAddr,
  input  logic         rdStb,
  input  logic         wrStb,
  output logic         addrAck,
  output ctrl_strobe_t strb
);
  localparam logic [REGNUM_W-1:0] LAST = REGNUM_W'(MAX_REG);

  logic                sel;
  logic                countSt;
  logic [REGNUM_W-1:0] ptr;
  logic                access;

  assign access = sel && !startStb && (rdStb || wrStb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sel     <= 1'b0;
      countSt <= 1'b1;
      ptr     <= '0;
    end else if (startStb) begin
      sel     <= (startAddr == DEV_ADDR);
      countSt <= 1'b1;
      ptr     <= '0;
    end else if (access) begin
      if (countSt) begin
        countSt <= 1'b0;
        ptr     <= '0;
      end else if (ptr == LAST) begin
        ptr <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign addrAck      = sel;
  assign strb.wrEn    = access && wrStb && !countSt;
  assign strb.inCount = countSt;
  assign strb.ptr     = ptr;
endmodule

// File: rtl/synth_dpath.sv
module synth_dpath
  import synth_pkg::*;
#(
  parameter int MAX_REG = 5,
  parameter int NUM_SEL = 5,
  parameter logic [3*NUM_SEL-1:0] TRUE_REG = '0,
  parameter logic [3*NUM_SEL-1:0] TRUE_BIT = '0,
  parameter logic [3*NUM_SEL-1:0] INV_REG  = '0,
  parameter logic [3*NUM_SEL-1:0] INV_BIT  = '0,
  parameter logic [8*(MAX_REG+1)-1:0] RESET_VALS = '0,
  parameter bit TRUE_FIXED = 1'b0,
  parameter bit REV_READ   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            strb,
  input  logic [7:0]              wrData,
  input  logic [NUM_SEL-1:0]      strapSel,
  output logic [7:0]              rdData,
  output logic [NUM_SEL-1:0]      freqIdx,
  output logic [8*(MAX_REG+1)-1:0] regFlat
);
  localparam int NREG = MAX_REG + 1;

  function automatic logic [7:0] resetByte(input int r, input logic [NUM_SEL-1:0] s);
    logic [7:0] v;
    v = RESET_VALS[8*r +: 8];
    for (int i = 0; i < NUM_SEL; i++) begin
      if (int'(TRUE_REG[3*i +: 3]) == r) v[TRUE_BIT[3*i +: 3]] = s[i];
      if (int'(INV_REG[3*i +: 3]) == r)  v[INV_BIT[3*i +: 3]]  = ~s[i];
    end
    return v;
  endfunction

  function automatic logic [7:0] keepMask(input int r);
    logic [7:0] m;
    m = 8'h00;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (int'(INV_REG[3*i +: 3]) == r) m[INV_BIT[3*i +: 3]] = 1'b1;
      if (TRUE_FIXED && int'(TRUE_REG[3*i +: 3]) == r) m[TRUE_BIT[3*i +: 3]] = 1'b1;
    end
    return m;
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [7:0] KEEP = keepMask(r);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= resetByte(r, strapSel);
      else if (strb.wrEn && strb.ptr == REGNUM_W'(r))
        q <= (q & KEEP) | (wrData & ~KEEP);
    end
    assign regFlat[8*r +: 8] = q;
  end

  logic [NUM_SEL-1:0] trueBits;
  logic [NUM_SEL-1:0] strappable;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    localparam logic [2:0] TR = TRUE_REG[3*i +: 3];
    localparam logic [2:0] TB = TRUE_BIT[3*i +: 3];
    localparam logic [2:0] IR = INV_REG[3*i +: 3];
    if (TR != NO_COPY) begin : g_true
      assign trueBits[i] = regFlat[8*int'(TR) + int'(TB)];
    end else begin : g_none
      assign trueBits[i] = 1'b0;
    end
    assign strappable[i] = (TR != NO_COPY) || (IR != NO_COPY);
  end

  assign freqIdx = (strapSel & strappable) | trueBits;

  logic [7:0] regByte;
  always_comb begin
    regByte = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (strb.ptr == REGNUM_W'(k)) regByte = regFlat[8*k +: 8];
    if (REV_READ && strb.ptr == '0) regByte = regByte & REV_MASK;
    rdData = strb.inCount ? 8'(NREG) : regByte;
  end
endmodule

// File: rtl/synth_regtarget.sv
module synth_regtarget
  import synth_pkg::*;
#(
  parameter int MAX_REG = 5,
  parameter int NUM_SEL = 5,
  parameter logic [3*NUM_SEL-1:0] TRUE_REG = {3'd7, 3'd4, 3'd1, 3'd1, 3'd1},
  parameter logic [3*NUM_SEL-1:0] TRUE_BIT = {3'd0, 3'd5, 3'd2, 3'd1, 3'd0},
  parameter logic [3*NUM_SEL-1:0] INV_REG  = {3'd7, 3'd7, 3'd3, 3'd2, 3'd2},
  parameter logic [3*NUM_SEL-1:0] INV_BIT  = {3'd0, 3'd0, 3'd0, 3'd6, 3'd7},
  parameter logic [8*(MAX_REG+1)-1:0] RESET_VALS =
    {8'h5A, 8'h00, 8'hA5, 8'h3C, 8'hF0, 8'h12},
  parameter bit TRUE_FIXED = 1'b0,
  parameter bit REV_READ   = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic [6:0]         startAddr,
  input  logic               rdStb,
  input  logic               wrStb,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  input  logic [NUM_SEL-1:0] strapSel,
  output logic [NUM_SEL-1:0] freqIdx,
  output logic               addrAck
);
  ctrl_strobe_t strb;
  logic [8*(MAX_REG+1)-1:0] regFlat;
  logic [REGNUM_W-1:0] curPtr;
  logic inCount;

  synth_ctrl #(.MAX_REG(MAX_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
    .rdStb(rdStb), .wrStb(wrStb), .addrAck(addrAck), .strb(strb)
  );

  synth_dpath #(
    .MAX_REG(MAX_REG), .NUM_SEL(NUM_SEL), .TRUE_REG(TRUE_REG), .TRUE_BIT(TRUE_BIT),
    .INV_REG(INV_REG), .INV_BIT(INV_BIT), .RESET_VALS(RESET_VALS),
    .TRUE_FIXED(TRUE_FIXED), .REV_READ(REV_READ)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .strapSel(strapSel),
    .rdData(rdData), .freqIdx(freqIdx), .regFlat(regFlat)
  );

  assign curPtr  = strb.ptr;
  assign inCount = strb.inCount;
endmodule

// File: rtl/synth_chk.sv
module synth_chk #(
  parameter int MAX_REG = 5,
  parameter int NUM_SEL = 5,
  parameter logic [3*NUM_SEL-1:0] TRUE_REG = '0,
  parameter logic [3*NUM_SEL-1:0] INV_REG  = '0,
  parameter logic [3*NUM_SEL-1:0] INV_BIT  = '0
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     startStb,
  input logic [6:0]               startAddr,
  input logic                     rdStb,
  input logic                     wrStb,
  input logic [7:0]               rdData,
  input logic [NUM_SEL-1:0]       strapSel,
  input logic [NUM_SEL-1:0]       freqIdx,
  input logic                     addrAck,
  input logic [2:0]               curPtr,
  input logic                     inCount,
  input logic [8*(MAX_REG+1)-1:0] regFlat
);
  localparam int NREG = MAX_REG + 1;

  function automatic logic [8*NREG-1:0] invMaskFlat();
    logic [8*NREG-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SEL; i++)
      if (int'(INV_REG[3*i +: 3]) < NREG)
        m[8*int'(INV_REG[3*i +: 3]) + int'(INV_BIT[3*i +: 3])] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_SEL-1:0] strapMask();
    logic [NUM_SEL-1:0] m;
    for (int i = 0; i < NUM_SEL; i++)
      m[i] = (TRUE_REG[3*i +: 3] != 3'd7) || (INV_REG[3*i +: 3] != 3'd7);
    return m;
  endfunction

  localparam logic [8*NREG-1:0]  INV_MASK = invMaskFlat();
  localparam logic [NUM_SEL-1:0] STRAP_OK = strapMask();

  // R1: address decode on start
  p_addr_sel_r1: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (addrAck == ($past(startAddr) == 7'h69)));

  // R1: a deselected block holds its registers
  p_unsel_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!addrAck && !startStb) |=> $stable(regFlat));

  // R2: count byte is presented in the count state
  p_count_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && inCount) |-> (rdData == 8'(NREG)));

  // R3: wrap after the last register
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && !inCount && !startStb && (rdStb || wrStb) && curPtr == 3'(MAX_REG))
    |=> (curPtr == 3'd0));

  // R4: write in count state stores nothing
  p_count_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && inCount && !startStb && wrStb)
    |=> ($stable(regFlat) && curPtr == 3'd0 && !inCount));

  // R5: inverted copies never change after reset
  p_inv_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> ((regFlat & INV_MASK) == ($past(regFlat) & INV_MASK)));

  // R7: strappable bits show through, register-only bits stay low
  p_index_r7: assert property (@(posedge clk) disable iff (!rstN)
    (((strapSel & STRAP_OK) & ~freqIdx) == '0) && ((freqIdx & ~STRAP_OK) == '0));
endmodule

bind synth_regtarget synth_chk #(
  .MAX_REG(MAX_REG), .NUM_SEL(NUM_SEL), .TRUE_REG(TRUE_REG),
  .INV_REG(INV_REG), .INV_BIT(INV_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
  .rdStb(rdStb), .wrStb(wrStb), .rdData(rdData), .strapSel(strapSel),
  .freqIdx(freqIdx), .addrAck(addrAck), .curPtr(curPtr), .inCount(inCount),
  .regFlat(regFlat)
);

// File: tb/sim_synth_regtarget.sv
module sim_synth_regtarget;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0;
  logic [6:0] startAddr = 7'h00;
  logic rdStb = 1'b0;
  logic wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [4:0] strapSel = 5'b10101;
  logic [7:0] rd0, rd1;
  logic [4:0] idx0, idx1;
  logic ack0, ack1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m0 [6];
  logic [7:0] m1 [6];
  bit mSel = 1'b0;
  bit mCount = 1'b1;
  int mPtr = 0;

  always #2 clk = ~clk;

  synth_regtarget u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .rdData(rd0),
    .strapSel(strapSel), .freqIdx(idx0), .addrAck(ack0)
  );

  synth_regtarget #(.TRUE_FIXED(1'b1), .REV_READ(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .rdData(rd1),
    .strapSel(strapSel), .freqIdx(idx1), .addrAck(ack1)
  );

  function automatic logic [7:0] keepOf(input int r, input bit fixedT);
    case (r)
      1: return fixedT ? 8'h07 : 8'h00;
      2: return 8'hC0;
      3: return 8'h01;
      4: return fixedT ? 8'h20 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] resetOf(input int r, input logic [4:0] s);
    logic [7:0] v;
    case (r)
      0: v = 8'h12;
      1: v = {5'b11110, s[2], s[1], s[0]};
      2: v = {~s[0], ~s[1], 6'b111100};
      3: v = {7'b1010010, ~s[2]};
      4: v = {2'b00, s[3], 5'b00000};
      default: v = 8'h5A;
    endcase
    return v;
  endfunction

  function automatic logic [4:0] idxOf(input logic [7:0] r1, input logic [7:0] r4,
                                      input logic [4:0] s);
    return (s & 5'h0F) | {1'b0, r4[5], r1[2:0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic advance();
    if (mCount) begin mCount = 1'b0; mPtr = 0; end
    else mPtr = (mPtr == 5) ? 0 : mPtr + 1;
  endtask

  task automatic checkIdx(input string tag);
    check({tag, "_idx_R7"}, 8'(idx0), 8'(idxOf(m0[1], m0[4], strapSel)));
    check({tag, "_idx_R6_u1"}, 8'(idx1), 8'(idxOf(m1[1], m1[4], strapSel)));
  endtask

  task automatic opStart(input logic [6:0] a);
    @(negedge clk);
    startStb = 1'b1; startAddr = a;
    @(negedge clk);
    startStb = 1'b0;
    mSel = (a == 7'h69); mCount = 1'b1; mPtr = 0;
    check("start_ack_R1", 8'(ack0), 8'(mSel));
  endtask

  task automatic opRead(input string tag);
    logic [7:0] e0, e1;
    @(negedge clk);
    if (mSel) begin
      e0 = mCount ? 8'd6 : m0[mPtr];
      e1 = mCount ? 8'd6 : ((mPtr == 0) ? (m1[0] & 8'h0B) : m1[mPtr]);
      check(tag, rd0, e0);
      check({tag, "_u1"}, rd1, e1);
    end
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    if (mSel) advance();
  endtask

  task automatic opWrite(input logic [7:0] d);
    logic [7:0] k;
    @(negedge clk);
    wrStb = 1'b1; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
    if (mSel) begin
      if (!mCount) begin
        k = keepOf(mPtr, 1'b0);
        m0[mPtr] = (m0[mPtr] & k) | (d & ~k);
        k = keepOf(mPtr, 1'b1);
        m1[mPtr] = (m1[mPtr] & k) | (d & ~k);
      end
      advance();
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      m0[i] = resetOf(i, strapSel);
      m1[i] = resetOf(i, strapSel);
    end
    @(negedge clk);
    check("reset_ack_R1", 8'(ack0), 8'h00);
    check("reset_idx_R8", 8'(idx0), 8'h05);
    checkIdx("reset_R8");

    // count byte, reset contents, revision read, wrap
    opStart(7'h69);
    opRead("count_R2");
    for (int i = 0; i < 6; i++) opRead("reset_reg_R8");
    opRead("wrap_R3");

    // write in count state
    opStart(7'h69);
    opWrite(8'hEE);
    opRead("countwr_R4");

    // protection of copies
    opStart(7'h69);
    opWrite(8'h00);
    opWrite(8'h33);
    opWrite(8'hFF);
    opWrite(8'h00);
    opWrite(8'hFE);
    opWrite(8'hFF);
    checkIdx("protect_R6");
    opStart(7'h69);
    opRead("count_R2");
    for (int i = 0; i < 6; i++) opRead("keep_R5");

    // foreign address
    opStart(7'h50);
    opWrite(8'h00);
    opWrite(8'h00);
    opRead("unsel_R1");
    opStart(7'h69);
    opRead("count_R2");
    for (int i = 0; i < 6; i++) opRead("unsel_hold_R1");
    check("rev_hold_R9", 8'(idx1), 8'(idxOf(m1[1], m1[4], strapSel)));

    // random mix
    for (int n = 0; n < 600; n++) begin
      r = $urandom % 10;
      if (r == 0) opStart(($urandom % 4 == 0) ? 7'($urandom) : 7'h69);
      else if (r < 5) opRead("rand_R3");
      else if (r < 9) opWrite(8'($urandom));
      else begin
        @(negedge clk);
        strapSel = 5'($urandom);
      end
      @(negedge clk);
      checkIdx("rand_R7");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule